// File: doc/BRIEF.md
# Synchronous BCD Decade Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit binary-coded decimal value and, on each rising clock edge, either loads a new digit from its data inputs, steps to the next decimal value, or keeps its value. The step sequence runs 0, 1, …, 9 and then back to 0. An active-low load strobe has the highest priority among the synchronous controls. Counting needs two enables, and both must be high.

The two enables have different roles when stages are chained. The trickle enable (`en_t`) also gates the terminal-count output. That output is high only when the stage holds 9 and `en_t` is high. It is a purely combinational function of the stored digit and `en_t`. A stage's `tc` can therefore drive the `en_t` of the next, more significant stage. The parallel enable (`en_p`) of every stage is tied to a common count strobe. This gives a look-ahead multi-digit decimal counter with no gates between stages.

An asynchronous active-low reset overrides everything and clears the digit at once. A value from 10 to 15 can be loaded, and it is shown as loaded. The first counting edge after that returns the stage to 0.

Top module: `bcd_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0 at once, without waiting for a clock edge, whatever the other inputs are.
- R2: With `load_n` low at a rising edge, `q` takes `din` after that edge, whatever the levels of `en_p` and `en_t`.
- R3: With `load_n`, `en_p` and `en_t` all high at a rising edge, a value of 0 to 8 in `q` becomes that value plus 1, and 9 becomes 0.
- R4: With `load_n` high and either `en_p` or `en_t` low at a rising edge, `q` keeps its value.
- R5: `tc` is 1 exactly when `q` equals 9 and `en_t` is 1. `tc` follows `en_t` with no clock edge and does not depend on `en_p` or `load_n`.
- R6: When `q` holds a value from 10 to 15 and counting is enabled (as in R3), the next rising edge makes `q` equal to 0.
- R7: Stages chained with each `tc` driving the next stage's `en_t` and a shared `en_p` count as one decimal number: three stages step 000 to 999 and then wrap to 000.
- R8: A loaded value from 10 to 15 appears unchanged on `q`, and `tc` stays 0 while it is held, even with `en_t` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every synchronous change happens on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low; overrides both enables |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `tc` |
| din | input | 4 | Digit to load |
| q | output | 4 | Current digit |
| tc | output | 1 | Terminal count: digit is 9 and `en_t` is high |

## Verification
The stored digit goes straight to `q`, so a wrong next-state choice shows on the port one edge after the stimulus that caused it. The bench samples one time step after each edge. A wrong terminal-count decode shows on `tc` in the same time step as the change of `en_t` or of the digit, with no clock edge needed. In a chain, an error in one digit shows as a mismatch against a reference integer within one cycle. A late or early carry is seen at the 9-to-0 boundary of the lower digits, and a missed wrap is seen at 999.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W    = 4;
    localparam int LAST_DIGIT = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t LAST_D = digit_t'(LAST_DIGIT);
    localparam digit_t ONE_D  = digit_t'(1);

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

    typedef struct packed {
        digit_t cnt;
    } stage_state_t;
endpackage

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
    import bcd_pkg::*;
(
    input  logic load_n,
    input  logic en_p,
    input  logic en_t,
    output op_e  op
);
    // Load wins over both enables; counting needs both enables high.
    always_comb begin
        if (!load_n)            op = OP_LOAD;
        else if (en_p && en_t)  op = OP_COUNT;
        else                    op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_next.sv
module bcd_next
    import bcd_pkg::*;
(
    input  op_e    op,
    input  digit_t cur,
    input  digit_t din,
    output digit_t nxt
);
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = din;
            // Last digit and any out-of-range code both go to zero.
            OP_COUNT: nxt = (cur >= LAST_D) ? '0 : cur + ONE_D;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_tc.sv
module bcd_tc
    import bcd_pkg::*;
(
    input  digit_t cnt,
    input  logic   en_t,
    output logic   tc
);
    always_comb tc = en_t && (cnt == LAST_D);
endmodule

// File: rtl/bcd_counter.sv
module bcd_counter
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               tc
);
    stage_state_t st_d, st_q;
    op_e          op;
    digit_t       nxt_cnt;

    bcd_mode_sel u_mode (
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    bcd_next u_next (
        .op  (op),
        .cur (st_q.cnt),
        .din (din),
        .nxt (nxt_cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bcd_tc u_tc (
        .cnt  (st_q.cnt),
        .en_t (en_t),
        .tc   (tc)
    );

    assign q = st_q.cnt;

    // R1: cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) p_reset_clear_r1: assert (q == '0);
    end

    p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t && q < LAST_D) |=> q == $past(q) + ONE_D);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t && q == LAST_D) |=> q == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    p_tc_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_t |-> !tc);

    p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t && q > LAST_D) |=> q == '0);

    p_no_tc_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q > LAST_D) |-> !tc);
endmodule

// File: tb/test_bcd_counter.sv
module test_bcd_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       tc;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_counter i_bcd_counter (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q), .tc(tc)
    );

    // Three-digit chain for R7
    logic       c_en;
    logic [3:0] c_q0, c_q1, c_q2;
    logic       c_tc0, c_tc1, c_tc2;

    bcd_counter i_dig0 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .en_p(c_en), .en_t(c_en),
                        .din(4'd0), .q(c_q0), .tc(c_tc0));
    bcd_counter i_dig1 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .en_p(c_en), .en_t(c_tc0),
                        .din(4'd0), .q(c_q1), .tc(c_tc1));
    bcd_counter i_dig2 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .en_p(c_en), .en_t(c_tc1),
                        .din(4'd0), .q(c_q2), .tc(c_tc2));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    task automatic t_reset();
        load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; din = 4'd7;
        tick();
        check(q == 4'd0, "R1 held reset", q, 0);
        load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
        rst_n = 1'b1;
        // load 5, then assert reset mid-cycle
        load_n = 1'b0; din = 4'd5; tick(); load_n = 1'b1;
        check(q == 4'd5, "R2 pre-reset load", q, 5);
        #2 rst_n = 1'b0; #1;
        check(q == 4'd0, "R1 async clear", q, 0);
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        load_n = 1'b0; din = 4'd0; tick(); load_n = 1'b1;
        en_p = 1'b1; en_t = 1'b1;
        for (int i = 0; i < 23; i++) begin
            tick();
            check(q == 4'((i + 1) % 10), "R3 count step", q, (i + 1) % 10);
        end
        en_p = 1'b0; en_t = 1'b0;
    endtask

    task automatic t_hold();
        load_n = 1'b0; din = 4'd4; tick(); load_n = 1'b1;
        en_p = 1'b0; en_t = 1'b1; tick();
        check(q == 4'd4, "R4 hold en_p low", q, 4);
        en_p = 1'b1; en_t = 1'b0; tick();
        check(q == 4'd4, "R4 hold en_t low", q, 4);
        en_p = 1'b0; en_t = 1'b0; din = 4'd8; tick();
        check(q == 4'd4, "R4 hold both low", q, 4);
    endtask

    task automatic t_load();
        load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; din = 4'd2; tick();
        check(q == 4'd2, "R2 load over enables", q, 2);
        din = 4'd6; tick();
        check(q == 4'd6, "R2 repeated load", q, 6);
        en_p = 1'b0; en_t = 1'b0; din = 4'd9; tick();
        check(q == 4'd9, "R2 load enables low", q, 9);
        load_n = 1'b1;
    endtask

    task automatic t_tc();
        load_n = 1'b0; din = 4'd9; tick(); load_n = 1'b1;
        en_p = 1'b0; en_t = 1'b1; #1;
        check(tc == 1'b1, "R5 tc at 9 en_t high", tc, 1);
        en_t = 1'b0; #1;
        check(tc == 1'b0, "R5 tc gated by en_t", tc, 0);
        en_t = 1'b1; load_n = 1'b0; din = 4'd3; #1;
        check(tc == 1'b1, "R5 tc ignores load_n", tc, 1);
        tick(); load_n = 1'b1; #1;
        check(tc == 1'b0, "R5 tc low at 3", tc, 0);
        en_t = 1'b0;
    endtask

    task automatic t_illegal();
        for (int v = 10; v < 16; v++) begin
            load_n = 1'b0; en_p = 1'b0; en_t = 1'b1; din = 4'(v); tick();
            load_n = 1'b1; #1;
            check(q == 4'(v), "R8 illegal load visible", q, v);
            check(tc == 1'b0, "R8 no tc on illegal", tc, 0);
            en_p = 1'b1; tick();
            check(q == 4'd0, "R6 recover to zero", q, 0);
            en_p = 1'b0; en_t = 1'b0;
        end
    endtask

    task automatic t_cascade();
        int ref_val;
        rst_n = 1'b0; c_en = 1'b0; tick(); rst_n = 1'b1;
        ref_val = 0;
        c_en = 1'b1;
        for (int i = 0; i < 1005; i++) begin
            tick();
            ref_val = (ref_val + 1) % 1000;
            check((int'(c_q2) * 100 + int'(c_q1) * 10 + int'(c_q0)) == ref_val, "R7 cascade",
                  int'(c_q2) * 100 + int'(c_q1) * 10 + int'(c_q0), ref_val);
        end
        c_en = 1'b0;
        tick();
        check((int'(c_q2) * 100 + int'(c_q1) * 10 + int'(c_q0)) == ref_val, "R7 cascade hold",
              int'(c_q2) * 100 + int'(c_q1) * 10 + int'(c_q0), ref_val);
    endtask

    initial begin
        c_en = 1'b0;
        #1;
        check(q == 4'd0, "R1 reset state", q, 0);
        check(tc == 1'b0, "R1 reset tc", tc, 0);
        t_reset();
        t_count();
        t_hold();
        t_load();
        t_tc();
        t_illegal();
        t_cascade();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule